// File: doc/BRIEF.md
# Serial Character Transmitter with Divisor Latch

This block sends characters on a single serial line. A host configures it through a byte-wide write port with a 3-bit address, laid out like a classic PC serial port. A 16-bit baud divisor divides the reference clock into a 16x oversampling tick. Each serial bit lasts 16 ticks, so one bit takes 16 × divisor reference cycles. With a 1.8432 MHz reference, a divisor of 1 gives 115200 baud, 12 gives 9600 baud and 96 gives 1200 baud.

The line control register sits at offset 3. Bit 7 of that register is the latch-access bit. While it is set, offsets 0 and 1 reach the low and high divisor bytes. While it is clear, a write to offset 0 hands a character to the transmitter. The transmitter takes a new character only when it is idle, and a busy output reports when a frame is in progress. Word length and stop-bit count come from the line control register. Both are captured when a frame starts.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, busy is low, the divisor is 1 and the line control register is 0x03 (8 data bits, 1 stop bit, access bit clear).
- R2: Every bit on the line lasts exactly 16 × divisor clock cycles. The divisor low byte is written at offset 0 and the high byte at offset 1, while line control bit 7 is 1.
- R3: A frame is one low start bit, then the data bits LSB first, then high stop bits. The start bit appears on the line in the cycle after the accepted write, and the line idles high.
- R4: Line control bits 1:0 select the word length as length minus 5 (00 = 5 bits, 11 = 8 bits). Only that many low data bits are sent.
- R5: Line control bit 2 selects one stop bit when 0 and two stop bits when 1.
- R6: Line control bits 6:3 are stored but change nothing on the line.
- R7: A write to offset 0 while line control bit 7 is 1 loads the divisor low byte and does not start a frame.
- R8: Busy goes high in the cycle after an accepted write and stays high until the last stop bit ends. A write to offset 0 while busy is ignored.
- R9: A divisor of 0 behaves as a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial output line, idle high |
| busy | output | 1 | High while a frame is being sent |

## Verification
The bench samples the line in the middle of every bit and on the last cycle of every bit. A bit period that is off by one cycle, or a start bit that is late, therefore shows up as a wrong level. Each of the four word lengths is sent, and the frame end is checked. A design that decoded the length field wrongly would put data where the stop bit belongs, or end the frame early. A write issued during a frame must leave the frame and the idle line after it unchanged. A write to offset 0 while the access bit is set must start nothing, and the frame sent afterwards must run at that byte's divisor. A divisor of 0 must give the same timing as a divisor of 1, and a design that let its counter wrap would stall the line. Setting the parity and break bits must leave a frame identical to one sent without them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;
    localparam int ADDR_W = 3;
    localparam int OVS    = 16;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic [DIV_W-1:0]  divisor,
    output logic [1:0]        wlen_code,
    output logic              two_stop,
    output logic              start,
    output logic [DATA_W-1:0] tx_byte
);
    localparam logic [ADDR_W-1:0] OFS_LO  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_LCR = ADDR_W'(3);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] lcr;
    } regs_t;

    regs_t r_d, r_q;
    logic  access;

    assign access = r_q.lcr[7];

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == OFS_LCR)
                r_d.lcr = wr_data;
            if (access && wr_addr == OFS_LO)
                r_d.div[7:0] = wr_data;
            if (access && wr_addr == OFS_HI)
                r_d.div[DIV_W-1:8] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.div <= DIV_W'(1);
            r_q.lcr <= 8'h03;
        end else begin
            r_q <= r_d;
        end
    end

    assign start     = wr_en && (wr_addr == OFS_LO) && !access && !busy;
    assign tx_byte   = wr_data;
    assign divisor   = r_q.div;
    assign wlen_code = r_q.lcr[1:0];
    assign two_stop  = r_q.lcr[2];

    assert_dlab_loads_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_LO && access) |=> (divisor[7:0] == $past(wr_data)));
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] eff_div;

    always_comb begin
        eff_div = (divisor == '0) ? DIV_W'(1) : divisor;
        tick    = (cnt_q >= eff_div - DIV_W'(1));
        if (restart)
            cnt_d = '0;
        else if (tick)
            cnt_d = '0;
        else
            cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && divisor > DIV_W'(1)) |=> (!tick || divisor <= DIV_W'(1)));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [1:0]        wlen_code,
    input  logic              two_stop,
    input  logic              tick,
    output logic              txd,
    output logic              busy
);
    localparam int SUB_W = $clog2(OVS);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shreg;
        logic [SUB_W-1:0]  sub;
        logic [CNT_W-1:0]  bit_cnt;
        logic [CNT_W-1:0]  last_bit;
        logic              two_stop;
        logic              txd;
    } shift_t;

    shift_t s_d, s_q;
    logic   bit_end;

    always_comb begin
        s_d     = s_q;
        bit_end = tick && (s_q.sub == SUB_W'(OVS - 1));
        if (s_q.state != TX_IDLE && tick)
            s_d.sub = s_q.sub + SUB_W'(1);
        case (s_q.state)
            TX_IDLE: begin
                s_d.txd = 1'b1;
                if (start) begin
                    s_d.state    = TX_START;
                    s_d.txd      = 1'b0;
                    s_d.shreg    = tx_byte;
                    s_d.sub      = '0;
                    s_d.bit_cnt  = '0;
                    s_d.last_bit = CNT_W'(wlen_code) + CNT_W'(4);
                    s_d.two_stop = two_stop;
                end
            end
            TX_START: if (bit_end) begin
                s_d.state   = TX_DATA;
                s_d.txd     = s_q.shreg[0];
                s_d.shreg   = s_q.shreg >> 1;
                s_d.bit_cnt = '0;
            end
            TX_DATA: if (bit_end) begin
                if (s_q.bit_cnt == s_q.last_bit) begin
                    s_d.state   = TX_STOP;
                    s_d.txd     = 1'b1;
                    s_d.bit_cnt = '0;
                end else begin
                    s_d.bit_cnt = s_q.bit_cnt + CNT_W'(1);
                    s_d.txd     = s_q.shreg[0];
                    s_d.shreg   = s_q.shreg >> 1;
                end
            end
            TX_STOP: if (bit_end) begin
                if (s_q.two_stop && s_q.bit_cnt == '0)
                    s_d.bit_cnt = CNT_W'(1);
                else
                    s_d.state = TX_IDLE;
            end
            default: s_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= TX_IDLE;
            s_q.txd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = s_q.txd;
    assign busy = (s_q.state != TX_IDLE);

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == TX_IDLE) |-> txd);
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == TX_START) |-> !txd);
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != TX_IDLE && !tick) |=> $stable(txd));
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == TX_DATA) |-> (s_q.bit_cnt <= s_q.last_bit));
    assert_one_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == TX_STOP && !s_q.two_stop) |-> (s_q.bit_cnt == '0));
    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (s_q.state == TX_IDLE));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        txd,
    output logic        busy
);
    logic [DIV_W-1:0]  divisor;
    logic [1:0]        wlen_code;
    logic              two_stop;
    logic              start;
    logic [DATA_W-1:0] tx_byte;
    logic              tick;

    sertx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .divisor   (divisor),
        .wlen_code (wlen_code),
        .two_stop  (two_stop),
        .start     (start),
        .tx_byte   (tx_byte)
    );

    sertx_baud u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (divisor),
        .restart (start),
        .tick    (tick)
    );

    sertx_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_byte   (tx_byte),
        .wlen_code (wlen_code),
        .two_stop  (two_stop),
        .tick      (tick),
        .txd       (txd),
        .busy      (busy)
    );

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       txd, busy;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sertx_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .txd(txd), .busy(busy)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic set_div(input logic [15:0] dv, input logic [7:0] lcr);
        wr(3'd3, 8'h80 | lcr);
        wr(3'd0, dv[7:0]);
        wr(3'd1, dv[15:8]);
        wr(3'd3, lcr);
    endtask

    // Sends data and checks every bit at mid-bit and last cycle of the bit.
    // inj > 0: a second write to offset 0 is issued at that cycle.
    task automatic send_check(input logic [7:0] data, input int nbits, input int nstop,
                              input int per, input int inj, input string tag);
        int total;
        bit injected;
        logic e;
        total = 1 + nbits + nstop;
        injected = 1'b0;
        wr(3'd0, data);
        cyc = 0;
        chk(busy, 1'b1, {tag, " busy rise R8"});
        chk(txd, 1'b0, {tag, " start R3"});
        for (int b = 0; b < total; b++) begin
            e = (b == 0) ? 1'b0 : (b <= nbits) ? data[b-1] : 1'b1;
            if (inj > 0 && !injected && b*per + per/2 > inj) begin
                wait_to(inj);
                wr_en = 1'b1; wr_addr = 3'd0; wr_data = ~data;
                wait_to(inj + 1);
                wr_en = 1'b0;
                injected = 1'b1;
            end
            wait_to(b*per + per/2);
            chk(txd, e, {tag, " mid-bit R3 R4 R5"});
            wait_to(b*per + per - 1);
            chk(txd, e, {tag, " bit end R2"});
        end
        chk(busy, 1'b1, {tag, " busy hold R8"});
        wait_to(total*per);
        chk(busy, 1'b0, {tag, " busy fall R8"});
        chk(txd, 1'b1, {tag, " idle R3"});
    endtask

    task automatic t_reset;
        chk(txd, 1'b1, "R1 txd after reset");
        chk(busy, 1'b0, "R1 busy after reset");
        send_check(8'hA5, 8, 1, 16, 0, "R1 default config");
    endtask

    task automatic t_divisor;
        set_div(16'd3, 8'h03);
        send_check(8'h3C, 8, 1, 48, 0, "R2 div3");
        set_div(16'h0102, 8'h00);
        send_check(8'h16, 5, 1, 16*258, 0, "R2 div high byte");
    endtask

    task automatic t_div_zero;
        set_div(16'd0, 8'h03);
        send_check(8'h5A, 8, 1, 16, 0, "R9 div0");
    endtask

    task automatic t_wlen;
        set_div(16'd1, 8'h00);
        send_check(8'hFF, 5, 1, 16, 0, "R4 5 bits");
        wr(3'd3, 8'h01);
        send_check(8'hEA, 6, 1, 16, 0, "R4 6 bits");
        wr(3'd3, 8'h02);
        send_check(8'hC3, 7, 1, 16, 0, "R4 7 bits");
    endtask

    task automatic t_stop;
        wr(3'd3, 8'h07);
        send_check(8'h81, 8, 2, 16, 0, "R5 two stop");
        wr(3'd3, 8'h04);
        send_check(8'h0A, 5, 2, 16, 0, "R5 two stop 5 bits");
    endtask

    task automatic t_ignored_bits;
        wr(3'd3, 8'h7B);
        send_check(8'h96, 8, 1, 16, 0, "R6 bits 6:3 set");
    endtask

    task automatic t_dlab;
        wr(3'd3, 8'h83);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h05);
        chk(busy, 1'b0, "R7 no frame with access bit");
        repeat (20) @(negedge clk);
        chk(txd, 1'b1, "R7 line idle with access bit");
        wr(3'd3, 8'h03);
        send_check(8'h71, 8, 1, 80, 0, "R7 loaded divisor");
    endtask

    task automatic t_busy_ignore;
        set_div(16'd1, 8'h03);
        send_check(8'h0F, 8, 1, 16, 40, "R8 write while busy");
        repeat (40) @(negedge clk);
        chk(busy, 1'b0, "R8 no second frame");
        chk(txd, 1'b1, "R8 line idle after ignored write");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divisor();
        t_div_zero();
        t_wlen();
        t_stop();
        t_ignored_bits();
        t_dlab();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule